// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits next to a small 8-bit processor core. It collects eleven interrupt sources and picks the one the core should service next. The sources are two timers, two serial channels, six external pins and one combined source. The combined source merges a transfer-busy event and a one-second tick. Sources are paired into six groups. Each group takes one of four priority levels, built from one bit in each of two level registers. The bit from the "high" register is the upper bit of the level. The bit from the "low" register is the lower bit.

Every source keeps a pending flag. Timer and serial flags are set by a one-cycle event pulse. External pins are active low and can be set per pin to edge or level sensing. A global enable and a per-source enable decide which pending flags compete. The winner is the request with the highest level. Among requests of equal level, the one with the lowest source index wins. The winner is offered to the core only if its level is strictly above every level already in service.

When the core accepts the request, the block marks that level in service and clears the source's flag by hardware. The combined source is the exception: its flag is not cleared on accept. A return pulse from the core retires the highest level in service. The two sub-source flags of the combined source stay set until software clears them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset there is no request, the in-service mask is 0000, both sub-source flags are 0, and the watchdog status bit is 0. All enables are off and every group is at level 0.
- R2: The level of group g is {high[g], low[g]}, where 00 is the lowest and 11 the highest. A pending request of a higher level wins over any request of a lower level, whatever the polling order.
- R3: Among requests of equal level, the lowest source index wins. Source indices are: 0 ext0, 1 serial1, 2 timer0, 3 ext2, 4 ext1, 5 ext3, 6 timer1, 7 ext4, 8 serial0, 9 ext5, 10 combined. Group = index/2. The vector output carries the index.
- R4: A request competes only when enable bit 11 (global) and the source's enable bit (bit = source index) are both 1. Flags keep latching while their source is disabled.
- R5: A request is offered only if its level is strictly greater than the highest level marked in service. A request at an equal or lower level waits.
- R6: An accept pulse while a request is offered sets the in-service bit of that level. A return pulse clears the highest set in-service bit.
- R7: Accepting a request clears the flag of sources 0 to 9 in the same edge.
- R8: Source 10 requests when (sub-flags AND sub-enables) is non-zero. Bit 0 is transfer-busy and bit 1 is the one-second tick. Sub-flags are set by their event pulses and survive an accept. They are cleared only by the software clear input.
- R9: Bit 6 of the low level register only stores the watchdog status bit and has no effect on arbitration.
- R10: An external pin in edge mode sets its flag on a high-then-low pair of consecutive samples. The request appears after the second clock edge following the fall. A pin held low does not set the flag again.
- R11: An external pin in level mode sets its flag from the inverted sampled pin every cycle. Its request appears two edges after the pin goes low and is gone two edges after it goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_lo_we | input | 1 | Write strobe for the low level register |
| lvl_lo_wdata | input | 7 | Low level bits per group [5:0]; bit 6 is the watchdog status bit |
| lvl_hi_we | input | 1 | Write strobe for the high level register |
| lvl_hi_wdata | input | 6 | High level bits per group |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 12 | Per-source enables [10:0]; global enable [11] |
| sub_en_we | input | 1 | Write strobe for the sub-source enables |
| sub_en_wdata | input | 2 | Sub-source enables (0 transfer-busy, 1 tick) |
| sub_clr | input | 2 | Software clear of the sub-source flags |
| ext_n | input | 6 | Active-low external pins 0 to 5 |
| ext_edge | input | 6 | Per-pin mode: 1 edge, 0 level |
| per_evt | input | 4 | Event pulses: 0 timer0, 1 timer1, 2 serial0, 3 serial1 |
| sub_evt | input | 2 | Event pulses: 0 transfer-busy, 1 tick |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_reti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | 4 | Source index of the offered request |
| irq_lvl | output | 2 | Level of the offered request |
| isr_mask | output | 4 | In-service level mask |
| sub_flags | output | 2 | Sub-source flags of the combined source |
| wdog_stat | output | 1 | Stored watchdog status bit |

## Verification
The bench builds the block with the package defaults: six groups, four levels, eleven sources and six external pins. With these values every level can be stacked in service, so preemption across three levels and same-level blocking can both be reached. Ties are checked across groups and inside a group. The combined source is run through its sub-enables and its sticky flags, and both pin sensing modes are run with their two-sample latency.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int GROUPS = 6;
    localparam int LEVELS = 4;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int SRC_N  = 2 * GROUPS - 1;
    localparam int VEC_W  = $clog2(SRC_N);
    localparam int EXT_N  = 6;
    localparam int PER_N  = 4;
    localparam int SUB_N  = 2;
    localparam int COMBO_SRC = SRC_N - 1;
    localparam int EN_W   = SRC_N + 1;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        lvl_t             lvl;
    } pick_t;

    // source index of external pin k
    function automatic int ext_src(input int k);
        case (k)
            0:       return 0;
            1:       return 4;
            2:       return 3;
            3:       return 5;
            4:       return 7;
            default: return 9;
        endcase
    endfunction

    // source index of peripheral event k: timer0, timer1, serial0, serial1
    function automatic int per_src(input int k);
        case (k)
            0:       return 2;
            1:       return 6;
            2:       return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int src_grp(input int s);
        return s / 2;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [EXT_N-1:0]   ext_n,
    input  logic [EXT_N-1:0]   ext_edge,
    input  logic [PER_N-1:0]   per_evt,
    input  logic [SUB_N-1:0]   sub_evt,
    input  logic [SUB_N-1:0]   sub_en,
    input  logic [SUB_N-1:0]   sub_clr,
    input  logic [SRC_N-2:0]   hw_clr,
    output logic [SRC_N-1:0]   flags,
    output logic [SUB_N-1:0]   sub_flags
);

    logic [EXT_N-1:0] smp_now, smp_old;
    logic [SRC_N-2:0] fl_q, fl_nxt;
    logic [SUB_N-1:0] sub_q;

    always_comb begin
        fl_nxt = fl_q & ~hw_clr;
        for (int k = 0; k < EXT_N; k++) begin
            if (ext_edge[k]) begin
                if (smp_old[k] && !smp_now[k]) fl_nxt[ext_src(k)] = 1'b1;
            end else begin
                fl_nxt[ext_src(k)] = ~smp_now[k];
            end
        end
        for (int k = 0; k < PER_N; k++) begin
            if (per_evt[k]) fl_nxt[per_src(k)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_now <= '1;
            smp_old <= '1;
            fl_q    <= '0;
            sub_q   <= '0;
        end else begin
            smp_now <= ext_n;
            smp_old <= smp_now;
            fl_q    <= fl_nxt;
            sub_q   <= (sub_q & ~sub_clr) | sub_evt;
        end
    end

    assign flags     = {|(sub_q & sub_en), fl_q};
    assign sub_flags = sub_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [SRC_N-1:0]  req,
    input  logic [GROUPS-1:0] lvl_lo,
    input  logic [GROUPS-1:0] lvl_hi,
    output pick_t             pick
);

    // scan from the last source down; ">=" lets the lower index take ties
    always_comb begin
        pick = '0;
        for (int s = SRC_N - 1; s >= 0; s--) begin
            lvl_t l;
            l = {lvl_hi[src_grp(s)], lvl_lo[src_grp(s)]};
            if (req[s] && (!pick.valid || l >= pick.lvl)) begin
                pick.valid = 1'b1;
                pick.vec   = VEC_W'(s);
                pick.lvl   = l;
            end
        end
    end

endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  lvl_t              take_lvl,
    input  logic              reti,
    output logic [LEVELS-1:0] isr,
    output logic              busy,
    output lvl_t              top_lvl
);

    logic [LEVELS-1:0] isr_q, isr_nxt;

    always_comb begin
        logic done;
        done    = 1'b0;
        isr_nxt = isr_q;
        if (reti) begin
            for (int i = LEVELS - 1; i >= 0; i--) begin
                if (!done && isr_nxt[i]) begin
                    isr_nxt[i] = 1'b0;
                    done       = 1'b1;
                end
            end
        end
        if (take) isr_nxt[take_lvl] = 1'b1;
    end

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (isr_q[i]) top_lvl = lvl_t'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= isr_nxt;
    end

    assign isr  = isr_q;
    assign busy = |isr_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_lo_we,
    input  logic [GROUPS:0]   lvl_lo_wdata,
    input  logic              lvl_hi_we,
    input  logic [GROUPS-1:0] lvl_hi_wdata,
    input  logic              en_we,
    input  logic [EN_W-1:0]   en_wdata,
    input  logic              sub_en_we,
    input  logic [SUB_N-1:0]  sub_en_wdata,
    input  logic [SUB_N-1:0]  sub_clr,
    input  logic [EXT_N-1:0]  ext_n,
    input  logic [EXT_N-1:0]  ext_edge,
    input  logic [PER_N-1:0]  per_evt,
    input  logic [SUB_N-1:0]  sub_evt,
    input  logic              irq_ack,
    input  logic              irq_reti,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [LVL_W-1:0]  irq_lvl,
    output logic [LEVELS-1:0] isr_mask,
    output logic [SUB_N-1:0]  sub_flags,
    output logic              wdog_stat
);

    logic [GROUPS-1:0] lo_q, hi_q;
    logic [SRC_N-1:0]  en_q;
    logic              glb_q;
    logic [SUB_N-1:0]  sub_en_q;
    logic              wdog_q;

    logic [SRC_N-1:0]  flags;
    logic [SRC_N-1:0]  live;
    logic [SRC_N-2:0]  hw_clr;
    pick_t             pick;
    logic              busy;
    lvl_t              top_lvl;
    logic              grant;
    logic              take;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q     <= '0;
            hi_q     <= '0;
            en_q     <= '0;
            glb_q    <= 1'b0;
            sub_en_q <= '0;
            wdog_q   <= 1'b0;
        end else begin
            if (lvl_lo_we) begin
                lo_q   <= lvl_lo_wdata[GROUPS-1:0];
                wdog_q <= lvl_lo_wdata[GROUPS];
            end
            if (lvl_hi_we) hi_q <= lvl_hi_wdata;
            if (en_we) begin
                en_q  <= en_wdata[SRC_N-1:0];
                glb_q <= en_wdata[EN_W-1];
            end
            if (sub_en_we) sub_en_q <= sub_en_wdata;
        end
    end

    irq_flag_bank u_flags (
        .clk      (clk),
        .rst      (rst),
        .ext_n    (ext_n),
        .ext_edge (ext_edge),
        .per_evt  (per_evt),
        .sub_evt  (sub_evt),
        .sub_en   (sub_en_q),
        .sub_clr  (sub_clr),
        .hw_clr   (hw_clr),
        .flags    (flags),
        .sub_flags(sub_flags)
    );

    assign live = flags & en_q & {SRC_N{glb_q}};

    irq_arbiter u_arb (
        .req    (live),
        .lvl_lo (lo_q),
        .lvl_hi (hi_q),
        .pick   (pick)
    );

    assign grant = pick.valid && (!busy || (pick.lvl > top_lvl));
    assign take  = irq_ack && grant;
    // the combined source shifts out of range and keeps its sub-flags
    assign hw_clr = take ? ((SRC_N-1)'(1) << pick.vec) : '0;

    irq_nest_tracker u_nest (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_lvl(pick.lvl),
        .reti    (irq_reti),
        .isr     (isr_mask),
        .busy    (busy),
        .top_lvl (top_lvl)
    );

    assign irq_req   = grant;
    assign irq_vec   = pick.vec;
    assign irq_lvl   = pick.lvl;
    assign wdog_stat = wdog_q;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [LVL_W-1:0]  irq_lvl,
    input logic              irq_ack,
    input logic              irq_reti,
    input logic [LEVELS-1:0] isr_mask,
    input logic              glb_en,
    input logic [SUB_N-1:0]  sub_flags,
    input logic [SUB_N-1:0]  sub_clr
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!irq_req && isr_mask == '0 && sub_flags == '0));

    p_vec_range_r3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec < VEC_W'(SRC_N)));

    p_global_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !irq_req);

    p_strictly_above_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((isr_mask >> irq_lvl) == '0));

    p_accept_marks_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && !irq_reti) |=> isr_mask[$past(irq_lvl)]);

    p_return_drops_one_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_reti && !irq_ack && isr_mask != '0) |=>
        ($countones(isr_mask) == $countones($past(isr_mask)) - 1));

    p_sub_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ((sub_flags & ~sub_clr) != '0) |=>
        ((sub_flags & $past(sub_flags & ~sub_clr)) == $past(sub_flags & ~sub_clr)));

endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .irq_lvl  (irq_lvl),
    .irq_ack  (irq_ack),
    .irq_reti (irq_reti),
    .isr_mask (isr_mask),
    .glb_en   (glb_q),
    .sub_flags(sub_flags),
    .sub_clr  (sub_clr)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        lvl_lo_we;
    logic [6:0]  lvl_lo_wdata;
    logic        lvl_hi_we;
    logic [5:0]  lvl_hi_wdata;
    logic        en_we;
    logic [11:0] en_wdata;
    logic        sub_en_we;
    logic [1:0]  sub_en_wdata;
    logic [1:0]  sub_clr;
    logic [5:0]  ext_n;
    logic [5:0]  ext_edge;
    logic [3:0]  per_evt;
    logic [1:0]  sub_evt;
    logic        irq_ack;
    logic        irq_reti;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic [1:0]  irq_lvl;
    logic [3:0]  isr_mask;
    logic [1:0]  sub_flags;
    logic        wdog_stat;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst(rst),
        .lvl_lo_we(lvl_lo_we), .lvl_lo_wdata(lvl_lo_wdata),
        .lvl_hi_we(lvl_hi_we), .lvl_hi_wdata(lvl_hi_wdata),
        .en_we(en_we), .en_wdata(en_wdata),
        .sub_en_we(sub_en_we), .sub_en_wdata(sub_en_wdata),
        .sub_clr(sub_clr), .ext_n(ext_n), .ext_edge(ext_edge),
        .per_evt(per_evt), .sub_evt(sub_evt),
        .irq_ack(irq_ack), .irq_reti(irq_reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .isr_mask(isr_mask), .sub_flags(sub_flags), .wdog_stat(wdog_stat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_offer(input string tag, input logic [3:0] vec, input logic [1:0] lvl);
        check({tag, " req"}, 32'(irq_req), 32'd1);
        check({tag, " vec"}, 32'(irq_vec), 32'(vec));
        check({tag, " lvl"}, 32'(irq_lvl), 32'(lvl));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        lvl_lo_we = 0; lvl_lo_wdata = '0; lvl_hi_we = 0; lvl_hi_wdata = '0;
        en_we = 0; en_wdata = '0; sub_en_we = 0; sub_en_wdata = '0;
        sub_clr = '0; ext_n = '1; ext_edge = '0; per_evt = '0; sub_evt = '0;
        irq_ack = 0; irq_reti = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_lo(input logic [6:0] v);
        @(negedge clk); lvl_lo_we = 1; lvl_lo_wdata = v;
        @(negedge clk); lvl_lo_we = 0;
    endtask

    task automatic wr_hi(input logic [5:0] v);
        @(negedge clk); lvl_hi_we = 1; lvl_hi_wdata = v;
        @(negedge clk); lvl_hi_we = 0;
    endtask

    task automatic wr_en(input logic [11:0] v);
        @(negedge clk); en_we = 1; en_wdata = v;
        @(negedge clk); en_we = 0;
    endtask

    task automatic wr_sub_en(input logic [1:0] v);
        @(negedge clk); sub_en_we = 1; sub_en_wdata = v;
        @(negedge clk); sub_en_we = 0;
    endtask

    task automatic pulse_per(input logic [3:0] m);
        @(negedge clk); per_evt = m;
        @(negedge clk); per_evt = '0;
    endtask

    task automatic pulse_sub(input logic [1:0] m);
        @(negedge clk); sub_evt = m;
        @(negedge clk); sub_evt = '0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk); sub_clr = m;
        @(negedge clk); sub_clr = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    task automatic do_reti();
        @(negedge clk); irq_reti = 1;
        @(negedge clk); irq_reti = 0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 req", 32'(irq_req), 32'd0);
        check("R1 isr", 32'(isr_mask), 32'd0);
        check("R1 sub", 32'(sub_flags), 32'd0);
        check("R1 wdog", 32'(wdog_stat), 32'd0);
        pulse_per(4'b0001);
        check("R1 enables off", 32'(irq_req), 32'd0);
    endtask

    task automatic t_level_wins();
        do_reset();
        wr_en(12'hFFF);
        wr_hi(6'b001000);
        pulse_per(4'b0011);
        check_offer("R2 group3 level2", 4'd6, 2'd2);
        wr_lo(7'b0000010);
        wr_hi(6'b001010);
        check_offer("R2 group1 level3", 4'd2, 2'd3);
    endtask

    task automatic t_poll_order();
        do_reset();
        wr_en(12'hFFF);
        pulse_per(4'b1100);
        check_offer("R3 serial1 before serial0", 4'd1, 2'd0);
        pulse_per(4'b0010);
        check_offer("R3 serial1 before timer1", 4'd1, 2'd0);
        do_ack();
        check("R6 isr after accept", 32'(isr_mask), 32'h1);
        check("R5 same level waits", 32'(irq_req), 32'd0);
        do_reti();
        check_offer("R7 serial1 cleared, timer1 next", 4'd6, 2'd0);
    endtask

    task automatic t_enables();
        do_reset();
        wr_en(12'h7FF);
        pulse_per(4'b0001);
        check("R4 global off", 32'(irq_req), 32'd0);
        wr_en(12'hFFB);
        check("R4 source off", 32'(irq_req), 32'd0);
        wr_en(12'hFFF);
        check_offer("R4 flag kept while disabled", 4'd2, 2'd0);
    endtask

    task automatic t_preempt();
        do_reset();
        wr_en(12'hFFF);
        wr_lo(7'b0010010);
        wr_hi(6'b001000);
        pulse_per(4'b0001);
        check_offer("R5 timer0 level1", 4'd2, 2'd1);
        do_ack();
        check("R6 isr level1", 32'(isr_mask), 32'h2);
        pulse_per(4'b0100);
        check("R5 serial0 equal level blocked", 32'(irq_req), 32'd0);
        pulse_per(4'b0010);
        check_offer("R5 timer1 preempts", 4'd6, 2'd2);
        do_ack();
        check("R6 isr nested", 32'(isr_mask), 32'h6);
        do_reti();
        check("R6 return drops level2", 32'(isr_mask), 32'h2);
        check("R5 still blocked at level1", 32'(irq_req), 32'd0);
        do_reti();
        check("R6 all returned", 32'(isr_mask), 32'h0);
        check_offer("R5 serial0 released", 4'd8, 2'd1);
    endtask

    task automatic t_combined();
        do_reset();
        wr_en(12'hFFF);
        pulse_sub(2'b01);
        check("R8 sub flag set", 32'(sub_flags), 32'h1);
        check("R8 sub disabled", 32'(irq_req), 32'd0);
        wr_sub_en(2'b01);
        check_offer("R8 combined request", 4'd10, 2'd0);
        do_ack();
        check("R8 sub flag survives accept", 32'(sub_flags), 32'h1);
        do_reti();
        check_offer("R8 combined again", 4'd10, 2'd0);
        pulse_clr(2'b01);
        check("R8 software clear", 32'(sub_flags), 32'h0);
        check("R8 no request after clear", 32'(irq_req), 32'd0);
        pulse_sub(2'b10);
        check("R8 tick flag", 32'(sub_flags), 32'h2);
        check("R8 tick not enabled", 32'(irq_req), 32'd0);
    endtask

    task automatic t_ignored_bit();
        do_reset();
        wr_en(12'hFFF);
        pulse_per(4'b0101);
        check_offer("R9 before", 4'd2, 2'd0);
        wr_lo(7'b1000000);
        check("R9 wdog stored", 32'(wdog_stat), 32'd1);
        check_offer("R9 arbitration unchanged", 4'd2, 2'd0);
    endtask

    task automatic t_edge_pin();
        do_reset();
        wr_en(12'hFFF);
        @(negedge clk); ext_edge = 6'b111111;
        @(negedge clk); ext_n[1] = 1'b0;
        @(negedge clk);
        check("R10 one edge not yet", 32'(irq_req), 32'd0);
        @(negedge clk);
        check_offer("R10 ext1 edge", 4'd4, 2'd0);
        do_ack();
        do_reti();
        repeat (3) @(negedge clk);
        check("R10 held low no retrigger", 32'(irq_req), 32'd0);
        ext_n[1] = 1'b1;
        repeat (2) @(negedge clk);
        ext_n[1] = 1'b0;
        repeat (2) @(negedge clk);
        check_offer("R10 second fall", 4'd4, 2'd0);
    endtask

    task automatic t_level_pin();
        do_reset();
        wr_en(12'hFFF);
        @(negedge clk); ext_n[2] = 1'b0;
        @(negedge clk);
        check("R11 one edge not yet", 32'(irq_req), 32'd0);
        @(negedge clk);
        check_offer("R11 ext2 low", 4'd3, 2'd0);
        ext_n[2] = 1'b1;
        @(negedge clk);
        check("R11 still set one edge", 32'(irq_req), 32'd1);
        @(negedge clk);
        check("R11 gone after release", 32'(irq_req), 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_level_wins();
        t_poll_order();
        t_enables();
        t_preempt();
        t_combined();
        t_ignored_bit();
        t_edge_pin();
        t_level_pin();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule